// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block is the digital part of an integer-N feedback divider built around an external two-modulus prescaler. The prescaler divides the oscillator by P or by P+1, and this block decides which one. It does so through a modulus-control output. Each prescaler output edge reaches the block as a one-clock strobe. The block runs two down-counters: a swallow count A and a main count B. Over one output period the prescaler divides by P+1 for the first A of its pulses and by P for the other B−A. The feedback period is therefore N = B·P + A oscillator cycles, and any integer N can be reached once N is at least P² − P.

A separate reference divider turns reference-clock strobes into one output pulse every R strobes, which sets the phase-comparison rate. A single parallel write loads A, B and R together. A write is accepted only if it describes a valid pulse-swallow setting. An accepted write is held and takes effect at the next period boundary, so the period that is running is never shortened or stretched.

The control sequencer has three states. In `ST_IDLE` nothing is programmed yet. In `ST_SWALLOW` the prescaler is at P+1 and A is still non-zero. In `ST_MAIN` the prescaler is at P. Its transitions are:

- *start*: ST_IDLE to ST_SWALLOW when A ≠ 0, or to ST_MAIN when A = 0, on the first accepted write.
- *swallow done*: ST_SWALLOW to ST_MAIN on the prescaler pulse that takes A to zero.
- *wrap*: from ST_SWALLOW or ST_MAIN back to ST_SWALLOW or ST_MAIN, chosen by the reloaded A, on the pulse that ends the B count.

Top module: `swallow_div_ctrl`

## Requirements
- R1: Once running, the distance between consecutive `fb_pulse` assertions is exactly B·P + A clock-domain oscillator cycles, where A and B are the values in force for that period.
- R2: In each period `mod_ctl` is 1 (select P+1) for the first A prescaler pulses and 0 (select P) for the remaining B−A. It changes only on a consumed prescaler pulse or at the start from idle.
- R3: `fb_pulse` is a single-clock pulse. It is asserted in the clock after the prescaler pulse that completes the B count.
- R4: A write with B = 0 or B < A is rejected. It leaves the running and pending settings untouched and sets `cfg_err`, which stays at 1 until reset.
- R5: An accepted write takes effect at the next period boundary. Of several writes within one period, the last one wins. A write in the same clock as a boundary is used for the new period.
- R6: `ref_pulse` is a single-clock pulse issued on every R-th `ref_tick`. R = 0 behaves as R = 1.
- R7: A new R is taken up only when the reference divider completes its current count.
- R8: After reset `mod_ctl`, `fb_pulse` and `cfg_err` are 0 and the sequencer is idle. No `fb_pulse` is issued until a valid write arrives, and the reference divider divides by 1.
- R9: With A = 0, `mod_ctl` stays 0 for whole periods. With A = B, it stays 1 across period boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, carrying prescaler-output strobes and reference strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the three setting fields |
| cfg_swallow | input | $clog2(P) | Swallow count A |
| cfg_main | input | B_W | Main count B |
| cfg_ref | input | R_W | Reference division R |
| ref_tick | input | 1 | One strobe per reference cycle |
| presc_pulse | input | 1 | One strobe per prescaler output edge |
| mod_ctl | output | 1 | 1 selects divide by P+1, 0 selects divide by P |
| fb_pulse | output | 1 | Divided feedback pulse, once per N |
| ref_pulse | output | 1 | Divided reference pulse, once per R ticks |
| cfg_err | output | 1 | Sticky flag for a rejected write |

## Verification
The bench builds the block with P = 8, so A is 3 bits wide and periods stay under a few hundred clocks. This makes the A = 0 and A = B extremes, the one-pulse B = 1 period and settings on both sides of the P² − P = 56 contiguity point all cheap to reach. B and R keep their default widths. A prescaler model in the bench reads `mod_ctl` after each consumed pulse. The measured periods and swallow counts therefore check the control timing end to end.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } sdc_state_e;

endpackage

// File: rtl/sdc_cfg_stage.sv
module sdc_cfg_stage #(
    parameter int A_W = 6,
    parameter int B_W = 13,
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [R_W-1:0] r_in,
    output logic           accept,
    output logic [A_W-1:0] a_nx,
    output logic [B_W-1:0] b_nx,
    output logic [R_W-1:0] r_nx,
    output logic           err
);

    logic           valid;
    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;
    logic [R_W-1:0] r_q;

    // B must cover the swallow count and must not be zero
    assign valid  = (b_in != '0) && (b_in >= B_W'(a_in));
    assign accept = we && valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            r_q <= '0;
            err <= 1'b0;
        end else begin
            if (accept) begin
                a_q <= a_in;
                b_q <= b_in;
                r_q <= r_in;
            end
            if (we && !valid) begin
                err <= 1'b1;
            end
        end
    end

    // a write landing on a boundary is used at once
    assign a_nx = accept ? a_in : a_q;
    assign b_nx = accept ? b_in : b_q;
    assign r_nx = accept ? r_in : r_q;

endmodule

// File: rtl/sdc_swallow_fsm.sv
module sdc_swallow_fsm
    import sdc_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           presc_pulse,
    input  logic [A_W-1:0] a_nx,
    input  logic [B_W-1:0] b_nx,
    output logic           mod_ctl,
    output logic           fb_pulse,
    output logic           idle
);

    sdc_state_e     st_q, st_d;
    logic [A_W-1:0] cnt_a_q, cnt_a_d;
    logic [B_W-1:0] cnt_b_q, cnt_b_d;
    logic           wrap;
    logic           b_last;
    sdc_state_e     st_load;

    assign b_last  = (cnt_b_q == B_W'(1));
    assign st_load = (a_nx != '0) ? ST_SWALLOW : ST_MAIN;

    always_comb begin
        st_d    = st_q;
        cnt_a_d = cnt_a_q;
        cnt_b_d = cnt_b_q;
        wrap    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d    = st_load;
                    cnt_a_d = a_nx;
                    cnt_b_d = b_nx;
                end
            end
            ST_SWALLOW: begin
                if (presc_pulse) begin
                    if (b_last) begin
                        wrap    = 1'b1;
                        st_d    = st_load;
                        cnt_a_d = a_nx;
                        cnt_b_d = b_nx;
                    end else begin
                        cnt_a_d = cnt_a_q - 1'b1;
                        cnt_b_d = cnt_b_q - 1'b1;
                        if (cnt_a_q == A_W'(1)) begin
                            st_d = ST_MAIN;
                        end
                    end
                end
            end
            ST_MAIN: begin
                if (presc_pulse) begin
                    if (b_last) begin
                        wrap    = 1'b1;
                        st_d    = st_load;
                        cnt_a_d = a_nx;
                        cnt_b_d = b_nx;
                    end else begin
                        cnt_b_d = cnt_b_q - 1'b1;
                    end
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_a_q <= '0;
            cnt_b_q <= '0;
        end else begin
            st_q    <= st_d;
            cnt_a_q <= cnt_a_d;
            cnt_b_q <= cnt_b_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_ctl  <= 1'b0;
            fb_pulse <= 1'b0;
        end else begin
            mod_ctl  <= (st_d == ST_SWALLOW);
            fb_pulse <= wrap;
        end
    end

    assign idle = (st_q == ST_IDLE);

endmodule

// File: rtl/sdc_ref_div.sv
module sdc_ref_div #(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [R_W-1:0] r_nx,
    output logic           pulse
);

    logic [R_W-1:0] cnt_q;
    logic [R_W-1:0] r_eff;

    assign r_eff = (r_nx == '0) ? R_W'(1) : r_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= R_W'(1);
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt_q <= R_W'(1)) begin
                    pulse <= 1'b1;
                    cnt_q <= r_eff;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl #(
    parameter int P   = 64,
    parameter int B_W = 13,
    parameter int R_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [$clog2(P)-1:0] cfg_swallow,
    input  logic [B_W-1:0]       cfg_main,
    input  logic [R_W-1:0]       cfg_ref,
    input  logic                 ref_tick,
    input  logic                 presc_pulse,
    output logic                 mod_ctl,
    output logic                 fb_pulse,
    output logic                 ref_pulse,
    output logic                 cfg_err
);

    localparam int A_W = $clog2(P);

    logic           accept;
    logic [A_W-1:0] a_nx;
    logic [B_W-1:0] b_nx;
    logic [R_W-1:0] r_nx;
    logic           fsm_idle;

    sdc_cfg_stage #(.A_W(A_W), .B_W(B_W), .R_W(R_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .a_in   (cfg_swallow),
        .b_in   (cfg_main),
        .r_in   (cfg_ref),
        .accept (accept),
        .a_nx   (a_nx),
        .b_nx   (b_nx),
        .r_nx   (r_nx),
        .err    (cfg_err)
    );

    sdc_swallow_fsm #(.A_W(A_W), .B_W(B_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .presc_pulse (presc_pulse),
        .a_nx        (a_nx),
        .b_nx        (b_nx),
        .mod_ctl     (mod_ctl),
        .fb_pulse    (fb_pulse),
        .idle        (fsm_idle)
    );

    sdc_ref_div #(.R_W(R_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .r_nx  (r_nx),
        .pulse (ref_pulse)
    );

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [A_W-1:0] cfg_swallow,
    input logic [B_W-1:0] cfg_main,
    input logic           ref_tick,
    input logic           presc_pulse,
    input logic           mod_ctl,
    input logic           fb_pulse,
    input logic           ref_pulse,
    input logic           cfg_err,
    input logic           idle
);

    p_fb_on_presc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(presc_pulse));

    p_fb_not_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> !$past(idle));

    p_mod_falls_on_presc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctl) |-> $past(presc_pulse));

    p_mod_rises_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> (fb_pulse || $past(idle)));

    p_reject_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_main == '0 || cfg_main < B_W'(cfg_swallow))) |=> cfg_err);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_ref_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(ref_tick));

endmodule

bind swallow_div_ctrl sdc_checker #(.A_W($clog2(P)), .B_W(B_W)) u_sdc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_swallow (cfg_swallow),
    .cfg_main    (cfg_main),
    .ref_tick    (ref_tick),
    .presc_pulse (presc_pulse),
    .mod_ctl     (mod_ctl),
    .fb_pulse    (fb_pulse),
    .ref_pulse   (ref_pulse),
    .cfg_err     (cfg_err),
    .idle        (fsm_idle)
);

// File: tb/swallow_div_ctrl_tb_top.sv
module swallow_div_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P   = 8;
    localparam int A_W = $clog2(P);
    localparam int B_W = 13;
    localparam int R_W = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [A_W-1:0] cfg_swallow = '0;
    logic [B_W-1:0] cfg_main = '0;
    logic [R_W-1:0] cfg_ref = '0;
    logic           ref_tick = 1'b0;
    logic           presc_pulse = 1'b0;
    logic           mod_ctl;
    logic           fb_pulse;
    logic           ref_pulse;
    logic           cfg_err;

    swallow_div_ctrl #(.P(P), .B_W(B_W), .R_W(R_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_swallow (cfg_swallow),
        .cfg_main    (cfg_main),
        .cfg_ref     (cfg_ref),
        .ref_tick    (ref_tick),
        .presc_pulse (presc_pulse),
        .mod_ctl     (mod_ctl),
        .fb_pulse    (fb_pulse),
        .ref_pulse   (ref_pulse),
        .cfg_err     (cfg_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // settings model: last accepted write, sticky error
    int pend_a = 0;
    int pend_b = 0;
    int pend_r = 0;
    int err_exp = 0;

    int exp_n_q[$];
    int exp_a_q[$];
    int exp_r_q[$];
    int fb_seen = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one write, and the model of what it should do
    task automatic cfg_write(int a, int b, int r);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_swallow = A_W'(a);
        cfg_main    = B_W'(b);
        cfg_ref     = R_W'(r);
        if (b >= a && b != 0) begin
            pend_a = a;
            pend_b = b;
            pend_r = r;
        end else begin
            err_exp = 1;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check("R4 error flag", int'(cfg_err), err_exp);
    endtask

    task automatic wait_fb(int k);
        int target;
        target = fb_seen + k;
        while (fb_seen < target) @(negedge clk);
    endtask

    // prescaler model: divides by P or P+1 as mod_ctl asks after each pulse
    int pc = P;
    always @(negedge clk) begin
        if (presc_pulse) begin
            presc_pulse = 1'b0;
            pc = (mod_ctl ? P + 1 : P) - 1;
        end else if (pc <= 1) begin
            presc_pulse = 1'b1;
        end else begin
            pc--;
        end
    end

    // reference strobes, one every third clock
    int rt = 0;
    always @(negedge clk) begin
        rt++;
        ref_tick = (rt % 3 == 0);
    end

    // feedback monitor / scoreboard
    int cyc = 0;
    int swc = 0;
    bit have_prev = 1'b0;
    bit last_mod = 1'b0;
    bit last_fb = 1'b0;
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            cyc = 0; swc = 0; have_prev = 1'b0; last_mod = 1'b0; last_fb = 1'b0;
        end else begin
            cyc++;
            if (presc_pulse && last_mod) swc++;
            if (fb_pulse) begin
                fb_seen++;
                if (last_fb) check("R3 feedback pulse width", 2, 1);
                if (have_prev) begin
                    check("R1/R5 period length", cyc, exp_n_q.pop_front());
                    check("R2 swallow pulses per period", swc, exp_a_q.pop_front());
                end
                check("R2 mod_ctl at period start", int'(mod_ctl), int'(pend_a != 0));
                exp_n_q.push_back(pend_b * P + pend_a);
                exp_a_q.push_back(pend_a);
                have_prev = 1'b1;
                cyc = 0;
                swc = 0;
            end
            last_mod = mod_ctl;
            last_fb  = fb_pulse;
        end
    end

    // reference monitor
    int tk = 0;
    bit rprev = 1'b0;
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            tk = 0; rprev = 1'b0;
        end else begin
            if (ref_tick) tk++;
            if (ref_pulse) begin
                if (rprev) check("R6/R7 reference interval", tk, exp_r_q.pop_front());
                exp_r_q.push_back(pend_r == 0 ? 1 : pend_r);
                rprev = 1'b1;
                tk = 0;
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset mod_ctl", int'(mod_ctl), 0);
        check("R8 reset fb_pulse", int'(fb_pulse), 0);
        check("R8 reset cfg_err", int'(cfg_err), 0);

        repeat (150) @(negedge clk);
        check("R8 no feedback while idle", fb_seen, 0);

        // R4: B < A rejected while idle, nothing starts
        cfg_write(5, 2, 0);
        repeat (100) @(negedge clk);
        check("R4 rejected write starts nothing", fb_seen, 0);

        // valid start, N = 83
        cfg_write(3, 10, 4);
        wait_fb(5);

        // R5: two writes in one period, last wins; R9: A = 0
        repeat (37) @(negedge clk);
        cfg_write(6, 9, 3);
        repeat (5) @(negedge clk);
        cfg_write(0, 7, 0);
        wait_fb(3);
        cnt = 0;
        repeat (120) begin
            @(negedge clk);
            if (mod_ctl) cnt++;
        end
        check("R9 A=0 keeps mod_ctl low", cnt, 0);

        // R9: A = B keeps P+1 across boundaries
        cfg_write(7, 7, 5);
        wait_fb(2);
        cnt = 0;
        repeat (150) begin
            @(negedge clk);
            if (!mod_ctl) cnt++;
        end
        check("R9 A=B keeps mod_ctl high", cnt, 0);

        // R4: rejected while running, period unchanged
        cfg_write(6, 5, 2);
        wait_fb(2);
        cfg_write(0, 0, 2);
        wait_fb(2);

        // shortest period, B = 1
        cfg_write(1, 1, 2);
        wait_fb(6);

        // long period above the contiguity point
        cfg_write(2, 30, 7);
        wait_fb(3);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule